// File: doc/BRIEF.md
# Per-Wavefront Write-Completion Fence Table

This block sits inside a shader core and gives each wavefront a memory fence that needs no invalidation or acknowledgement traffic from other cores. Every store acknowledgement coming back from the shared cache carries a global write completion time. The table keeps the largest such time seen for each wavefront. It also keeps a count of that wavefront's stores that have been issued but not yet acknowledged.

When a wavefront executes a fence, its stall line rises and stays high while either of two conditions holds. The first is that the wavefront still has stores without an acknowledgement. The second is that the shared global time has not yet moved past the recorded completion time. Once both conditions are clear, every earlier store is past its lease in every L1, so a flag store placed after the fence cannot be observed before the data it guards. When the fence completes, the recorded time for that wavefront returns to zero.

The stall output is combinational from the table state and the current fence request. A fence that is already satisfied therefore never raises stall, and a held fence drops stall in the first cycle its condition is met.

Top module: `wf_fence_table`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears all stall outputs, all recorded times to 0 and all pending-store counts to 0.
- R2: A fence on wavefront w whose pending count is 0 and whose recorded time is strictly below `gtime` leaves `stall[w]` low in the fence cycle and raises nothing afterwards.
- R3: A store acknowledgement for wavefront w sets its recorded time to the larger of the current value and `ack_time`. A smaller `ack_time` never lowers it.
- R4: After a fence on w, `stall[w]` stays high while `gtime` is less than or equal to the recorded time. It drops in the first cycle in which `gtime` is strictly greater, provided no stores are pending.
- R5: After a fence on w, `stall[w]` stays high while the pending-store count of w is nonzero. An acknowledgement takes effect on the count at the clock edge that ends its cycle.
- R6: Stores, acknowledgements and fences for one wavefront never change the stall bit of another wavefront. Bit w of `stall` belongs to wavefront ID w.
- R7: When a fence on w completes, the recorded time of w becomes 0. A later fence then completes at once for any `gtime` above 0.
- R8: A stall bit is high only for a wavefront with a fence in progress, meaning a fence presented in this cycle or a held earlier one.
- R9: A store issue and a store acknowledgement for the same wavefront in the same cycle leave its pending count unchanged.
- R10: A fence presented for a wavefront whose fence is already held has no effect on that wavefront's stall or on its release condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_vld | input | 1 | A store is issued this cycle |
| st_wf | input | WFW | Wavefront ID of the issued store |
| ack_vld | input | 1 | A store acknowledgement arrives this cycle |
| ack_wf | input | WFW | Wavefront ID of the acknowledged store |
| ack_time | input | TW | Global write completion time of the acknowledged store |
| fence_vld | input | 1 | A fence is presented this cycle |
| fence_wf | input | WFW | Wavefront ID of the fence |
| gtime | input | TW | Current global time |
| stall | output | NWF | Per-wavefront fence hold, bit w for wavefront w |

## Verification
`stall` is a combinational function of the registered table and the inputs of the same cycle. A fence therefore shows its effect in the cycle it is presented. A change of `gtime` shows in the cycle it is applied. A store issue or acknowledgement acts only from the cycle after its clock edge. The bench drives every vector just after the falling edge and reads `stall` one nanosecond later, before the next rising edge. Each expected value is worked out from the state the earlier rows left behind. Rows are placed to expose edge cases: `gtime` equal to the recorded time, an acknowledgement in the same cycle as a held fence, and issue plus acknowledgement in one cycle.

// File: rtl/wf_fence_table.sv
module wf_fence_table #(
  parameter int NWF = 8,
  parameter int TW  = 32,
  parameter int PW  = 4,
  localparam int WFW = (NWF > 1) ? $clog2(NWF) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           st_vld,
  input  logic [WFW-1:0] st_wf,
  input  logic           ack_vld,
  input  logic [WFW-1:0] ack_wf,
  input  logic [TW-1:0]  ack_time,
  input  logic           fence_vld,
  input  logic [WFW-1:0] fence_wf,
  input  logic [TW-1:0]  gtime,
  output logic [NWF-1:0] stall
);

  logic [TW-1:0]  rec  [NWF];
  logic [PW-1:0]  pend [NWF];
  logic [NWF-1:0] armed;
  logic [NWF-1:0] fhit, shit, ahit, blocked, active;

  for (genvar w = 0; w < NWF; w++) begin : g_wf
    assign fhit[w]    = fence_vld && (fence_wf == WFW'(w));
    assign shit[w]    = st_vld    && (st_wf    == WFW'(w));
    assign ahit[w]    = ack_vld   && (ack_wf   == WFW'(w));
    assign blocked[w] = (pend[w] != '0) || !(gtime > rec[w]);
    assign active[w]  = armed[w] || fhit[w];
    assign stall[w]   = active[w] && blocked[w];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rec[w]   <= '0;
        pend[w]  <= '0;
        armed[w] <= 1'b0;
      end else begin
        if (shit[w] && !ahit[w])      pend[w] <= pend[w] + 1'b1;
        else if (!shit[w] && ahit[w]) pend[w] <= pend[w] - 1'b1;

        if (ahit[w])                      rec[w] <= (ack_time > rec[w]) ? ack_time : rec[w];
        else if (active[w] && !blocked[w]) rec[w] <= '0;

        if (active[w]) armed[w] <= blocked[w];
      end
    end

    a_r3_max_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ahit[w] |=> (rec[w] >= $past(ack_time)) && (rec[w] >= $past(rec[w])));

    a_r5_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (armed[w] && pend[w] != '0) |-> stall[w]);

    a_r4_released: assert property (@(posedge clk) disable iff (!rst_n)
      (armed[w] && pend[w] == '0 && gtime > rec[w]) |-> !stall[w]);

    a_r7_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (armed[w] && !stall[w] && !ahit[w]) |=> (rec[w] == '0));

    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (ahit[w] && !shit[w]) |-> (pend[w] != '0));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (shit[w] && !ahit[w]) |-> (pend[w] != '1));
  end

  a_r8_stall_needs_fence: assert property (@(posedge clk) disable iff (!rst_n)
    (stall & ~(armed | fhit)) == '0);

endmodule

// File: tb/sim_wf_fence_table.sv
module sim_wf_fence_table;
  localparam int NWF = 8;
  localparam int TW  = 32;
  localparam int WFW = 3;

  typedef struct packed {
    logic           sv;
    logic [WFW-1:0] sw;
    logic           av;
    logic [WFW-1:0] aw;
    logic [TW-1:0]  at;
    logic           fv;
    logic [WFW-1:0] fw;
    logic [TW-1:0]  gt;
    logic [NWF-1:0] exp;
    logic [3:0]     req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{0,0,0,0,  0,0,0,  5,8'h00,1},  // R1 idle after reset
    '{0,0,0,0,  0,1,0,  5,8'h00,2},  // R2 satisfied fence
    '{1,1,0,0,  0,0,0,  6,8'h00,8},  // R8
    '{0,0,1,1, 40,0,0,  6,8'h00,8},  // R8 ack, no fence
    '{1,1,0,0,  0,0,0,  6,8'h00,8},
    '{0,0,1,1, 20,0,0,  6,8'h00,3},  // R3 smaller ack
    '{0,0,0,0,  0,1,1, 10,8'h02,4},  // R4 held
    '{0,0,0,0,  0,0,0, 40,8'h02,3},  // R3/R4 equal time still held
    '{0,0,0,0,  0,0,0, 41,8'h00,4},  // R4 release
    '{0,0,0,0,  0,1,1,  2,8'h00,7},  // R7 entry cleared
    '{1,2,0,0,  0,0,0, 50,8'h00,8},
    '{0,0,0,0,  0,1,2, 50,8'h04,5},  // R5 pending holds
    '{0,0,1,2, 60,0,0,100,8'h04,5},  // R5 ack not yet counted
    '{0,0,0,0,  0,0,0,100,8'h00,5},  // R5 release
    '{1,3,0,0,  0,0,0,100,8'h00,8},
    '{1,3,1,3,105,0,0,100,8'h00,9},  // R9 issue+ack
    '{0,0,0,0,  0,1,3,200,8'h08,9},  // R9 one still pending
    '{0,0,1,3,150,0,0,200,8'h08,5},
    '{0,0,0,0,  0,0,0,200,8'h00,5},
    '{1,4,0,0,  0,0,0,200,8'h00,8},
    '{0,0,1,4,300,1,5,201,8'h00,6},  // R6 wf5 unaffected by wf4 ack
    '{0,0,0,0,  0,1,4,201,8'h10,4},
    '{0,0,0,0,  0,1,6,201,8'h10,6},  // R6 wf6 completes, wf4 held
    '{0,0,0,0,  0,1,4,250,8'h10,10}, // R10 repeat fence
    '{0,0,0,0,  0,0,0,301,8'h00,4},
    '{1,7,0,0,  0,0,0,301,8'h00,8},
    '{0,0,0,0,  0,1,7,301,8'h80,5},
    '{0,0,1,7,400,0,0,302,8'h80,5},
    '{0,0,0,0,  0,0,0,302,8'h80,4},
    '{0,0,0,0,  0,0,0,401,8'h00,4}
  };

  logic clk = 0, rst_n = 0;
  logic st_vld = 0, ack_vld = 0, fence_vld = 0;
  logic [WFW-1:0] st_wf = 0, ack_wf = 0, fence_wf = 0;
  logic [TW-1:0] ack_time = 0, gtime = 0;
  logic [NWF-1:0] stall;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  wf_fence_table u0 (
    .clk(clk), .rst_n(rst_n), .st_vld(st_vld), .st_wf(st_wf),
    .ack_vld(ack_vld), .ack_wf(ack_wf), .ack_time(ack_time),
    .fence_vld(fence_vld), .fence_wf(fence_wf), .gtime(gtime), .stall(stall)
  );

  task automatic check(input logic [NWF-1:0] exp, input int req);
    total++;
    if (stall !== exp) begin
      bad++;
      $display("FAIL R%0d stall=%h expected=%h", req, stall, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    st_vld = v.sv; st_wf = v.sw; ack_vld = v.av; ack_wf = v.aw; ack_time = v.at;
    fence_vld = v.fv; fence_wf = v.fw; gtime = v.gt;
    #1;
  endtask

  initial begin
    #1; check(8'h00, 1);  // R1 during reset
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check(VEC[i].exp, int'(VEC[i].req));
    end
    // R1: reset in the middle of a held fence
    drive('{1,0,0,0,0,0,0,500,8'h00,1});
    drive('{0,0,0,0,0,1,0,500,8'h01,5});
    drive('{0,0,0,0,0,0,0,500,8'h01,5});
    @(negedge clk);
    rst_n = 0; #1;
    check(8'h00, 1);  // R1 stall cleared
    @(negedge clk);
    rst_n = 1;
    drive('{0,0,0,0,0,1,0,1,8'h00,1});
    check(8'h00, 1);  // R1 pending count and time cleared
    drive('{0,0,0,0,0,0,0,1,8'h00,8});
    check(8'h00, 8);  // R8 nothing left held
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule